// File: doc/BRIEF.md
# Programmable Leaky Integrate-and-Fire Neuron

This block is one spiking neuron with a signed 8-bit membrane potential. Each run cycle it may add a signed input sample to the potential and may subtract a signed leak amount. If the result reaches the firing level, it emits a one-cycle spike and loads a programmable rest potential into the membrane.

The leak amount, the firing level, the rest potential and two mode enables sit in a small register file. Software writes them through an address and a write strobe. The write data shares the same 8-bit byte lane that carries the neuron input in run mode, so a cycle is either a configuration write or a neuron step. An enable input lets the surrounding logic pause the neuron between steps. The output byte carries the upper seven membrane bits together with the spike flag.

Top module: `lif_neuron`

## Requirements
- R1: While `rst_n` is low at a clock edge, the membrane is cleared to 0, the spike flag to 0, the leak amount to 0, the firing level to 127, the rest potential to 0 and both mode enables to 0, so `dout` reads 8'h00.
- R2: When `cfg_we` is high at a clock edge, `din` is written to the register selected by `cfg_addr`: 1 is the signed leak amount, 2 the signed firing level, 3 the signed rest potential, and 4 the mode register. At most one write happens per edge.
- R3: A write with `cfg_addr` equal to 0, 5, 6 or 7 changes no register.
- R4: Mode bit 0 enables integration: during a step, the signed value on `din` is added to the potential.
- R5: Mode bit 1 enables leak: during a step, the signed leak amount is subtracted from the potential. With both mode bits clear, a step leaves the potential unchanged.
- R6: The candidate potential is formed at 10-bit width and saturated to the range -128..127 before it is compared and stored.
- R7: If the saturated candidate is greater than or equal to the signed firing level, the spike flag is set and the membrane takes the rest potential. Otherwise the membrane takes the candidate and the spike flag is cleared.
- R8: A cycle with `cfg_we` high, or with both `cfg_we` and `run_en` low, keeps the membrane unchanged and clears the spike flag. A spike therefore lasts exactly one cycle per firing.
- R9: `dout` equals {membrane[7:1], spike}, valid the cycle after the edge that updated them.
- R10: With firing level 32, leak 2, input 8 and both mode bits set, the potential gains 6 per step from 0 and fires on every sixth step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe; high means write, low means run |
| cfg_addr | input | 3 | Configuration register select |
| din | input | 8 | Write data when strobing, signed neuron input otherwise |
| run_en | input | 1 | Neuron step enable while the strobe is low |
| dout | output | 8 | {membrane[7:1], spike} |

## Verification
The bound checker monitors behaviour that is local to one cycle on every clock. A firing cycle leaves the membrane at the rest potential. A write or an idle cycle holds the membrane and clears the spike. A step that does not fire stores a value below the firing level. The arithmetic itself (saturation at both ends, leak with a negative amount, the register map, ignored addresses, the reset defaults and the six-step firing period) only shows up in the bench's scenarios. There, a reference model predicts every output byte.

// File: rtl/lif_pkg.sv
// Package: shared constants for the leaky integrate-and-fire neuron.
// Assumes a 3-bit configuration address; mode bit positions are fixed.
package lif_pkg;
    localparam int unsigned LIF_AW = 3;
    localparam logic [LIF_AW-1:0] REG_LEAK  = 3'd1;
    localparam logic [LIF_AW-1:0] REG_FIRE  = 3'd2;
    localparam logic [LIF_AW-1:0] REG_REST  = 3'd3;
    localparam logic [LIF_AW-1:0] REG_MODE  = 3'd4;
    localparam int unsigned MODE_INTEG_BIT = 0;
    localparam int unsigned MODE_LEAK_BIT  = 1;
endpackage

// File: rtl/lif_cfg_regs.sv
// Module: configuration register file for the neuron.
// Holds leak amount, firing level, rest potential and two mode enables.
// Assumes one write per clock; unmapped addresses are dropped.
module lif_cfg_regs
    import lif_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int signed FIRE_INIT = 127
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [LIF_AW-1:0]    addr,
    input  logic [DW-1:0]        wdata,
    output logic signed [DW-1:0] leak,
    output logic signed [DW-1:0] fire_lvl,
    output logic signed [DW-1:0] rest,
    output logic                 integ_en,
    output logic                 leak_en
);
    // Register update: reset defaults, else decode address on strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            leak     <= '0;
            fire_lvl <= DW'(FIRE_INIT);
            rest     <= '0;
            integ_en <= 1'b0;
            leak_en  <= 1'b0;
        end else if (we) begin
            case (addr)
                REG_LEAK: leak     <= wdata;
                REG_FIRE: fire_lvl <= wdata;
                REG_REST: rest     <= wdata;
                REG_MODE: begin
                    integ_en <= wdata[MODE_INTEG_BIT];
                    leak_en  <= wdata[MODE_LEAK_BIT];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/lif_update.sv
// Module: combinational step of the membrane potential.
// Widens to DW+2 bits, applies integration and leak, saturates to DW bits,
// and compares with the firing level. Assumes two's complement operands.
module lif_update #(
    parameter int unsigned DW = 8
) (
    input  logic signed [DW-1:0] mem,
    input  logic signed [DW-1:0] sample,
    input  logic signed [DW-1:0] leak,
    input  logic signed [DW-1:0] fire_lvl,
    input  logic                 integ_en,
    input  logic                 leak_en,
    output logic signed [DW-1:0] cand,
    output logic                 fire
);
    localparam int unsigned CW = DW + 2;
    localparam logic signed [CW-1:0] SAT_HI = {3'b000, {(DW-1){1'b1}}};
    localparam logic signed [CW-1:0] SAT_LO = {3'b111, {(DW-1){1'b0}}};

    logic signed [CW-1:0] mem_w, add_w, sub_w, sum_w;

    // Widen operands and form the unsaturated sum.
    always_comb begin
        mem_w = {{2{mem[DW-1]}}, mem};
        add_w = integ_en ? {{2{sample[DW-1]}}, sample} : '0;
        sub_w = leak_en  ? {{2{leak[DW-1]}}, leak}     : '0;
        sum_w = mem_w + add_w - sub_w;
    end

    // Clamp to the DW-bit signed range and test the firing level.
    always_comb begin
        if (sum_w > SAT_HI)      cand = SAT_HI[DW-1:0];
        else if (sum_w < SAT_LO) cand = SAT_LO[DW-1:0];
        else                     cand = sum_w[DW-1:0];
        fire = (cand >= fire_lvl);
    end
endmodule

// File: rtl/lif_state.sv
// Module: membrane and spike registers.
// Loads a new potential only on a step; a write or idle cycle holds it.
module lif_state #(
    parameter int unsigned DW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step,
    input  logic                 fire,
    input  logic signed [DW-1:0] cand,
    input  logic signed [DW-1:0] rest,
    output logic signed [DW-1:0] mem,
    output logic                 spike
);
    // Membrane update and single-cycle spike flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem   <= '0;
            spike <= 1'b0;
        end else if (step) begin
            mem   <= fire ? rest : cand;
            spike <= fire;
        end else begin
            spike <= 1'b0;
        end
    end
endmodule

// File: rtl/lif_neuron.sv
// Module: top of the leaky integrate-and-fire neuron.
// The din lane carries write data while cfg_we is high and the signed
// neuron input otherwise; a step occurs when cfg_we is low and run_en high.
module lif_neuron
    import lif_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int signed FIRE_INIT = 127
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [LIF_AW-1:0] cfg_addr,
    input  logic [DW-1:0]     din,
    input  logic              run_en,
    output logic [DW-1:0]     dout
);
    logic signed [DW-1:0] cfg_leak, cfg_fire, cfg_rest;
    logic                 cfg_integ, cfg_leak_en;
    logic signed [DW-1:0] cand, mem_q;
    logic                 fire, spike_q, step;

    // A step is a non-write cycle with the enable high.
    always_comb step = !cfg_we && run_en;

    lif_cfg_regs #(.DW(DW), .FIRE_INIT(FIRE_INIT)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(din),
        .leak(cfg_leak), .fire_lvl(cfg_fire), .rest(cfg_rest),
        .integ_en(cfg_integ), .leak_en(cfg_leak_en)
    );

    lif_update #(.DW(DW)) u_upd (
        .mem(mem_q), .sample(din), .leak(cfg_leak), .fire_lvl(cfg_fire),
        .integ_en(cfg_integ), .leak_en(cfg_leak_en), .cand(cand), .fire(fire)
    );

    lif_state #(.DW(DW)) u_st (
        .clk(clk), .rst_n(rst_n), .step(step), .fire(fire), .cand(cand),
        .rest(cfg_rest), .mem(mem_q), .spike(spike_q)
    );

    // Pack the upper membrane bits with the spike flag.
    always_comb dout = {mem_q[DW-1:1], spike_q};
endmodule

// File: rtl/lif_neuron_chk.sv
// Module: property checker bound to lif_neuron.
// Observes the strobe, enable, stored membrane, spike and configuration.
module lif_neuron_chk #(
    parameter int unsigned DW = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_we,
    input logic                 run_en,
    input logic signed [DW-1:0] mem_q,
    input logic                 spike_q,
    input logic signed [DW-1:0] cfg_fire,
    input logic signed [DW-1:0] cfg_rest
);
    // R7
    fire_loads_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spike_q |-> (mem_q == cfg_rest));
    // R7
    quiet_below_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && run_en) |=> (spike_q || (mem_q < cfg_fire)));
    // R8
    write_holds_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (mem_q == $past(mem_q)));
    // R8
    write_no_spike_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !spike_q);
    // R8
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && !run_en) |=> (!spike_q && $stable(mem_q)));
endmodule

bind lif_neuron lif_neuron_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .run_en(run_en),
    .mem_q(mem_q), .spike_q(spike_q), .cfg_fire(cfg_fire), .cfg_rest(cfg_rest)
);

// File: tb/lif_neuron_tb.sv
// Bench: directed corner cases plus seeded random traffic, each cycle
// compared with a reference model built from the requirements.
module lif_neuron_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] din = '0;
    logic       run_en = 1'b0;
    logic [7:0] dout;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Reference state
    int m_leak = 0, m_fire = 127, m_rest = 0, m_mem = 0;
    bit m_integ = 0, m_lk = 0, m_spk = 0;
    int spike_cnt = 0;

    always #2 clk = ~clk;

    lif_neuron u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .din(din), .run_en(run_en), .dout(dout)
    );

    function automatic int sx(input logic [7:0] v);
        return (v > 127) ? int'(v) - 256 : int'(v);
    endfunction

    function automatic int clamp(input int v);
        if (v > 127) return 127;
        if (v < -128) return -128;
        return v;
    endfunction

    function automatic logic [7:0] expect_out();
        logic [7:0] b;
        b = 8'(m_mem);
        return {b[7:1], m_spk};
    endfunction

    task automatic check(input string tag, input logic [7:0] exp);
        n_chk++;
        if (dout !== exp) begin
            n_bad++;
            $display("FAIL %s: dout=%h expected=%h", tag, dout, exp);
        end
    endtask

    // One clock: drive at negedge, update model at posedge, compare after.
    task automatic cyc(input bit we, input logic [2:0] a, input logic [7:0] d,
                       input bit en, input string tag);
        int c;
        @(negedge clk);
        cfg_we = we; cfg_addr = a; din = d; run_en = en;
        @(posedge clk);
        if (we) begin
            m_spk = 0;
            case (a)
                3'd1: m_leak = sx(d);
                3'd2: m_fire = sx(d);
                3'd3: m_rest = sx(d);
                3'd4: begin m_integ = d[0]; m_lk = d[1]; end
                default: ;
            endcase
        end else if (en) begin
            c = clamp(m_mem + (m_integ ? sx(d) : 0) - (m_lk ? m_leak : 0));
            if (c >= m_fire) begin m_spk = 1; m_mem = m_rest; spike_cnt++; end
            else begin m_spk = 0; m_mem = c; end
        end else begin
            m_spk = 0;
        end
        #1;
        check(tag, expect_out());
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d, input string tag);
        cyc(1, a, d, 0, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; cfg_we = 0; run_en = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        m_leak = 0; m_fire = 127; m_rest = 0; m_mem = 0;
        m_integ = 0; m_lk = 0; m_spk = 0;
    endtask

    initial begin
        int first_spk;
        void'($urandom(32'd1234));
        do_reset();
        #1;
        check("R1 reset output", 8'h00);
        // R1/R5: mode 0 after reset: steps change nothing
        cyc(0, 0, 8'd50, 1, "R1 R5 mode cleared");
        // R1: firing level 127 after reset
        wr(3'd4, 8'h01, "R2 mode write");
        cyc(0, 0, 8'd100, 1, "R1 R4 integrate below 127");
        cyc(0, 0, 8'd100, 1, "R6 R7 saturate to 127 fires");
        cyc(0, 0, 8'd5, 0, "R8 idle clears spike");
        // R3: unmapped writes ignored; R8 write holds membrane
        cyc(0, 0, 8'd40, 1, "R4 integrate");
        wr(3'd0, 8'h80, "R3 addr0 ignored");
        wr(3'd5, 8'h80, "R3 addr5 ignored");
        wr(3'd6, 8'h03, "R3 addr6 ignored");
        wr(3'd7, 8'h81, "R3 addr7 ignored");
        cyc(0, 0, 8'd40, 1, "R3 config unchanged");
        // R5 leak, R6 negative saturation
        wr(3'd4, 8'h02, "R2 leak only");
        wr(3'd1, 8'd127, "R2 leak write");
        cyc(0, 0, 8'd0, 1, "R5 leak subtract");
        cyc(0, 0, 8'd0, 1, "R6 saturate low");
        cyc(0, 0, 8'd0, 1, "R6 hold at -128");
        // negative leak raises potential
        wr(3'd1, 8'h80, "R2 leak -128");
        cyc(0, 0, 8'd0, 1, "R5 negative leak");
        // R10: the documented six-step period
        do_reset();
        wr(3'd2, 8'd32, "R2 level 32");
        wr(3'd1, 8'd2, "R2 leak 2");
        wr(3'd4, 8'h03, "R2 both modes");
        first_spk = spike_cnt;
        for (int i = 1; i <= 12; i++) begin
            cyc(0, 0, 8'd8, 1, "R10 six-step period");
            n_chk++;
            if (dout[0] !== ((i % 6) == 0)) begin
                n_bad++;
                $display("FAIL R10 step %0d: spike=%b expected=%b", i, dout[0], (i % 6) == 0);
            end
        end
        n_chk++;
        if (spike_cnt - first_spk != 2) begin
            n_bad++;
            $display("FAIL R10: spikes=%0d expected=2", spike_cnt - first_spk);
        end
        // R7 rest potential nonzero, negative level fires every step
        wr(3'd3, 8'hF0, "R2 rest -16");
        wr(3'd2, 8'hE0, "R2 level -32");
        cyc(0, 0, 8'd1, 1, "R7 fire to rest");
        cyc(0, 0, 8'd1, 1, "R7 fire again");
        // Random traffic, R9 packing checked every cycle
        for (int i = 0; i < 2000; i++) begin
            bit w, e;
            w = ($urandom % 8) == 0;
            e = ($urandom % 8) != 0;
            cyc(w, 3'($urandom % 8), 8'($urandom), e, "R9 random");
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule